// File: doc/BRIEF.md
# Protection-Fault Exception Entry Unit

This block sits next to the memory management unit of a CPU core and performs the hardware side of a data-access protection fault. Such a fault means a translation entry matched the virtual address, but the rights recorded in that entry do not allow the requested access. The block receives a fault strobe with its context: the faulting virtual address, an access-operation code, the faulting PC, a delay-slot flag with the PC of the enclosing branch, the live status word, the stack-pointer register and the vector base. In one step it fills the exception context registers, hands back a new status word for the core to write, and issues a redirect to the handler entry point.

The status word is owned by the core. The block reads it through `cur_sr` and changes it only through the one-cycle `sr_wr_en` / `sr_wr_data` write port. A return-from-exception request restores the saved status word and redirects to the saved PC. A fault that arrives while exceptions are blocked is refused and reported on a separate error pulse.

Top module: `prot_fault_entry`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every output is zero.
- R2: For an accepted fault, `page_num` becomes `flt_va[VA_W-1:PAGE_SHIFT]` (bits above a 4 KB offset by default) and `fault_addr` becomes all of `flt_va`.
- R3: `evt_code` becomes 0x0C0 when `flt_op` is a write-class code (1 store, 4 cache invalidate, 5 allocate-store). It becomes 0x0A0 for every other code (0 load, 2 cache purge, 3 cache write-back, 6 and 7 reserved).
- R4: `saved_pc` becomes `flt_pc`, or `flt_branch_pc` when `flt_in_slot` is 1.
- R5: `saved_sr` becomes `cur_sr` and `saved_sp` becomes `cur_r15`, both as sampled with the fault.
- R6: For an accepted fault `sr_wr_en` pulses and `sr_wr_data` equals `cur_sr` with bits 30 (mode), 29 (bank) and 28 (block) set to 1 and all other bits unchanged.
- R7: A fault is accepted when `flt_req` is high and `cur_sr` bit 28 is 0. One clock later, `redir_vld` is high for exactly that cycle with `redir_pc` = `cur_vbr` + 0x100, and all register updates of R2–R6 appear in that same cycle.
- R8: A fault with `cur_sr` bit 28 set is not accepted. `nest_err` pulses for one cycle, no redirect or status write occurs, and the context registers keep their values.
- R9: `rte_req` (with no fault accepted in the same cycle) gives a one-cycle `redir_vld` with `redir_pc` = `saved_pc` and a status write of `saved_sr`. The context registers are left unchanged.
- R10: When an accepted fault and `rte_req` arrive together, the fault wins and the return is dropped.
- R11: With neither request high, `redir_vld`, `sr_wr_en` and `nest_err` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_req | input | 1 | Protection-fault strobe |
| flt_va | input | VA_W | Faulting virtual address |
| flt_op | input | 3 | Access-operation code |
| flt_pc | input | PC_W | PC of faulting instruction |
| flt_in_slot | input | 1 | Fault taken in a delay slot |
| flt_branch_pc | input | PC_W | PC of the delayed branch |
| cur_sr | input | SR_W | Live status word |
| cur_r15 | input | REG_W | Live stack-pointer register |
| cur_vbr | input | PC_W | Vector base |
| rte_req | input | 1 | Return-from-exception request |
| redir_vld | output | 1 | One-cycle redirect pulse |
| redir_pc | output | PC_W | Redirect target |
| sr_wr_en | output | 1 | Status-word write strobe |
| sr_wr_data | output | SR_W | New status word |
| page_num | output | VA_W-PAGE_SHIFT | Page number of faulting address |
| fault_addr | output | VA_W | Full faulting address |
| evt_code | output | 12 | Exception event code |
| saved_pc | output | PC_W | Saved PC |
| saved_sr | output | SR_W | Saved status word |
| saved_sp | output | REG_W | Saved stack pointer |
| nest_err | output | 1 | Fault refused while blocked |

## Verification
Every path in the block has one register stage, so a wrong internal value shows up at the ports in the cycle right after the request that caused it. A wrong read/write classification appears as the wrong `evt_code`. A lost delay-slot choice shows in `saved_pc`, and it shows again one return later in `redir_pc`. A bad block-bit test appears as a redirect where `nest_err` was expected, or as a refusal where a redirect was expected. A context register that is corrupted during a refused fault or a return stays wrong until the next accepted fault, so the bench reads those registers after each such event.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  localparam int EVT_W = 12;
  localparam logic [EVT_W-1:0] EVT_READ  = 12'h0A0;
  localparam logic [EVT_W-1:0] EVT_WRITE = 12'h0C0;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_PURGE  = 3'd2,
    OP_WBACK  = 3'd3,
    OP_INVAL  = 3'd4,
    OP_ALLOC  = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } acc_op_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_ENTER,
    ACT_RETURN,
    ACT_REFUSE
  } act_e;
endpackage

// File: rtl/pfe_access_classify.sv
module pfe_access_classify
  import pfe_pkg::*;
(
  input  logic [2:0]       op,
  output logic             is_write,
  output logic [EVT_W-1:0] code
);
  acc_op_e op_e;

  always_comb begin
    op_e = acc_op_e'(op);
    unique case (op_e)
      OP_STORE, OP_INVAL, OP_ALLOC: is_write = 1'b1;
      default:                      is_write = 1'b0;
    endcase
    code = is_write ? EVT_WRITE : EVT_READ;
  end
endmodule

// File: rtl/pfe_pc_select.sv
module pfe_pc_select #(
  parameter int PC_W = 32
) (
  input  logic            in_slot,
  input  logic [PC_W-1:0] insn_pc,
  input  logic [PC_W-1:0] branch_pc,
  output logic [PC_W-1:0] save_pc
);
  always_comb save_pc = in_slot ? branch_pc : insn_pc;
endmodule

// File: rtl/pfe_sr_update.sv
module pfe_sr_update #(
  parameter int SR_W   = 32,
  parameter int MD_BIT = 30,
  parameter int RB_BIT = 29,
  parameter int BL_BIT = 28
) (
  input  logic [SR_W-1:0] sr_in,
  output logic [SR_W-1:0] sr_entry
);
  localparam int NSET = 3;
  localparam int SET_POS [NSET] = '{MD_BIT, RB_BIT, BL_BIT};

  logic [SR_W-1:0] set_mask;

  for (genvar g = 0; g < SR_W; g++) begin : g_mask
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NSET; k++)
        if (SET_POS[k] == g) hit = 1'b1;
    end
    assign set_mask[g] = hit;
  end

  always_comb sr_entry = sr_in | set_mask;
endmodule

// File: rtl/prot_fault_entry.sv
module prot_fault_entry
  import pfe_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PC_W       = 32,
  parameter int SR_W       = 32,
  parameter int REG_W      = 32,
  parameter int MD_BIT     = 30,
  parameter int RB_BIT     = 29,
  parameter int BL_BIT     = 28,
  parameter logic [31:0] VEC_OFF = 32'h0000_0100,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_req,
  input  logic [VA_W-1:0]   flt_va,
  input  logic [2:0]        flt_op,
  input  logic [PC_W-1:0]   flt_pc,
  input  logic              flt_in_slot,
  input  logic [PC_W-1:0]   flt_branch_pc,
  input  logic [SR_W-1:0]   cur_sr,
  input  logic [REG_W-1:0]  cur_r15,
  input  logic [PC_W-1:0]   cur_vbr,
  input  logic              rte_req,
  output logic              redir_vld,
  output logic [PC_W-1:0]   redir_pc,
  output logic              sr_wr_en,
  output logic [SR_W-1:0]   sr_wr_data,
  output logic [VPN_W-1:0]  page_num,
  output logic [VA_W-1:0]   fault_addr,
  output logic [EVT_W-1:0]  evt_code,
  output logic [PC_W-1:0]   saved_pc,
  output logic [SR_W-1:0]   saved_sr,
  output logic [REG_W-1:0]  saved_sp,
  output logic              nest_err
);
  logic             is_write;
  logic [EVT_W-1:0] code_nxt;
  logic [PC_W-1:0]  spc_nxt;
  logic [SR_W-1:0]  sr_entry;
  logic [PC_W-1:0]  vec_target;
  act_e             act;

  pfe_access_classify u_cls (
    .op       (flt_op),
    .is_write (is_write),
    .code     (code_nxt)
  );

  pfe_pc_select #(.PC_W(PC_W)) u_pcs (
    .in_slot   (flt_in_slot),
    .insn_pc   (flt_pc),
    .branch_pc (flt_branch_pc),
    .save_pc   (spc_nxt)
  );

  pfe_sr_update #(
    .SR_W(SR_W), .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .BL_BIT(BL_BIT)
  ) u_sru (
    .sr_in    (cur_sr),
    .sr_entry (sr_entry)
  );

  always_comb vec_target = cur_vbr + PC_W'(VEC_OFF);

  // Request arbitration: an accepted fault outranks a return.
  always_comb begin
    act = ACT_NONE;
    if (flt_req && !cur_sr[BL_BIT])   act = ACT_ENTER;
    else if (rte_req)                 act = ACT_RETURN;
    if (flt_req && cur_sr[BL_BIT] && !rte_req) act = ACT_REFUSE;
  end

  logic refuse;
  always_comb refuse = flt_req && cur_sr[BL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_vld  <= 1'b0;
      redir_pc   <= '0;
      sr_wr_en   <= 1'b0;
      sr_wr_data <= '0;
      page_num   <= '0;
      fault_addr <= '0;
      evt_code   <= '0;
      saved_pc   <= '0;
      saved_sr   <= '0;
      saved_sp   <= '0;
      nest_err   <= 1'b0;
    end else begin
      redir_vld <= 1'b0;
      sr_wr_en  <= 1'b0;
      nest_err  <= refuse;
      unique case (act)
        ACT_ENTER: begin
          page_num   <= flt_va[VA_W-1:PAGE_SHIFT];
          fault_addr <= flt_va;
          evt_code   <= code_nxt;
          saved_pc   <= spc_nxt;
          saved_sr   <= cur_sr;
          saved_sp   <= cur_r15;
          sr_wr_en   <= 1'b1;
          sr_wr_data <= sr_entry;
          redir_vld  <= 1'b1;
          redir_pc   <= vec_target;
        end
        ACT_RETURN: begin
          sr_wr_en   <= 1'b1;
          sr_wr_data <= saved_sr;
          redir_vld  <= 1'b1;
          redir_pc   <= saved_pc;
        end
        default: ;
      endcase
    end
  end

  logic unused_w;
  always_comb unused_w = is_write;
endmodule

// File: rtl/pfe_checker.sv
module pfe_checker #(
  parameter int VA_W  = 32,
  parameter int PC_W  = 32,
  parameter int SR_W  = 32,
  parameter int REG_W = 32,
  parameter int MD_BIT = 30,
  parameter int RB_BIT = 29,
  parameter int BL_BIT = 28,
  parameter logic [31:0] VEC_OFF = 32'h0000_0100
) (
  input logic             clk,
  input logic             rst,
  input logic             flt_req,
  input logic             rte_req,
  input logic [SR_W-1:0]  cur_sr,
  input logic [PC_W-1:0]  cur_vbr,
  input logic             redir_vld,
  input logic [PC_W-1:0]  redir_pc,
  input logic             sr_wr_en,
  input logic [SR_W-1:0]  sr_wr_data,
  input logic [VA_W-1:0]  fault_addr,
  input logic [11:0]      evt_code,
  input logic [PC_W-1:0]  saved_pc,
  input logic [SR_W-1:0]  saved_sr,
  input logic             nest_err
);
  p_vector_r7: assert property (@(posedge clk) disable iff (rst)
    (flt_req && !cur_sr[BL_BIT]) |=>
      (redir_vld && redir_pc == $past(cur_vbr) + PC_W'(VEC_OFF)));

  p_code_r3: assert property (@(posedge clk) disable iff (rst)
    (flt_req && !cur_sr[BL_BIT]) |=>
      (evt_code == 12'h0A0 || evt_code == 12'h0C0));

  p_mode_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (flt_req && !cur_sr[BL_BIT]) |=>
      (sr_wr_en && sr_wr_data[MD_BIT] && sr_wr_data[RB_BIT] && sr_wr_data[BL_BIT]));

  p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    (flt_req && cur_sr[BL_BIT]) |=>
      (nest_err && $stable(fault_addr) && $stable(saved_pc) && $stable(saved_sr)));

  p_return_r9: assert property (@(posedge clk) disable iff (rst)
    (rte_req && !(flt_req && !cur_sr[BL_BIT])) |=>
      (redir_vld && redir_pc == saved_pc && sr_wr_data == saved_sr));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!flt_req && !rte_req) |=> (!redir_vld && !sr_wr_en && !nest_err));
endmodule

bind prot_fault_entry pfe_checker #(
  .VA_W(VA_W), .PC_W(PC_W), .SR_W(SR_W), .REG_W(REG_W),
  .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .BL_BIT(BL_BIT), .VEC_OFF(VEC_OFF)
) u_chk (
  .clk(clk), .rst(rst), .flt_req(flt_req), .rte_req(rte_req),
  .cur_sr(cur_sr), .cur_vbr(cur_vbr), .redir_vld(redir_vld),
  .redir_pc(redir_pc), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
  .fault_addr(fault_addr), .evt_code(evt_code), .saved_pc(saved_pc),
  .saved_sr(saved_sr), .nest_err(nest_err)
);

// File: tb/prot_fault_entry_test.sv
`timescale 1ns/1ps
module prot_fault_entry_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flt_req = 1'b0;
  logic [31:0] flt_va = '0;
  logic [2:0]  flt_op = '0;
  logic [31:0] flt_pc = '0;
  logic        flt_in_slot = 1'b0;
  logic [31:0] flt_branch_pc = '0;
  logic [31:0] cur_sr = '0;
  logic [31:0] cur_r15 = '0;
  logic [31:0] cur_vbr = '0;
  logic        rte_req = 1'b0;
  logic        redir_vld;
  logic [31:0] redir_pc;
  logic        sr_wr_en;
  logic [31:0] sr_wr_data;
  logic [19:0] page_num;
  logic [31:0] fault_addr;
  logic [11:0] evt_code;
  logic [31:0] saved_pc;
  logic [31:0] saved_sr;
  logic [31:0] saved_sp;
  logic        nest_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prot_fault_entry uut (.*);

  // {op, slot, expected code, va, pc, branch pc, sr}
  localparam int NV = 8;
  localparam logic [143:0] VEC [NV] = '{
    {3'd0, 1'b0, 12'h0A0, 32'h1234_5678, 32'h8C00_1000, 32'h8C00_0FFE, 32'h0000_00F0},
    {3'd1, 1'b0, 12'h0C0, 32'hFFFF_F004, 32'h8C00_2000, 32'h8C00_1FFE, 32'h0000_0001},
    {3'd2, 1'b1, 12'h0A0, 32'h0000_1FFF, 32'h8C00_3002, 32'h8C00_3000, 32'h0000_0300},
    {3'd3, 1'b0, 12'h0A0, 32'hA5A5_A000, 32'h8C00_4000, 32'h8C00_3FFE, 32'h8000_0000},
    {3'd4, 1'b1, 12'h0C0, 32'h7000_0FFF, 32'h8C00_5006, 32'h8C00_5004, 32'h0000_00FF},
    {3'd5, 1'b0, 12'h0C0, 32'h0001_2345, 32'h8C00_6000, 32'h8C00_5FFE, 32'h2000_0000},
    {3'd6, 1'b1, 12'h0A0, 32'hDEAD_BEEF, 32'h8C00_700A, 32'h8C00_7008, 32'h0000_0002},
    {3'd1, 1'b1, 12'h0C0, 32'h0000_0000, 32'h8C00_8002, 32'h8C00_8000, 32'h4000_0000}
  };

  localparam logic [31:0] ENTRY_BITS = 32'h7000_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    flt_req = 1'b0;
    rte_req = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_va, last_bpc, last_sr;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs zero during reset
    chk("R1 redir_vld", {31'b0, redir_vld}, 32'd0);
    chk("R1 fault_addr", fault_addr, 32'd0);
    chk("R1 saved_pc", saved_pc, 32'd0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after release evt_code", {20'b0, evt_code}, 32'd0);
    chk("R11 idle redir", {31'b0, redir_vld}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [143:0] v;
      logic [31:0] vbr, r15, exp_spc;
      v = VEC[i];
      vbr = 32'h8000_0000 + (i << 12);
      r15 = v[127:96] ^ 32'h5A5A_5A5A;
      exp_spc = v[140] ? v[63:32] : v[95:64];
      @(negedge clk);
      flt_req = 1'b1;
      flt_op = v[143:141];
      flt_in_slot = v[140];
      flt_va = v[127:96];
      flt_pc = v[95:64];
      flt_branch_pc = v[63:32];
      cur_sr = v[31:0];
      cur_r15 = r15;
      cur_vbr = vbr;
      @(posedge clk); #1;
      chk("R2 page_num", {12'b0, page_num}, {12'b0, v[127:108]});
      chk("R2 fault_addr", fault_addr, v[127:96]);
      chk("R3 evt_code", {20'b0, evt_code}, {20'b0, v[139:128]});
      chk("R4 saved_pc", saved_pc, exp_spc);
      chk("R5 saved_sr", saved_sr, v[31:0]);
      chk("R5 saved_sp", saved_sp, r15);
      chk("R6 sr_wr_en", {31'b0, sr_wr_en}, 32'd1);
      chk("R6 sr_wr_data", sr_wr_data, v[31:0] | ENTRY_BITS);
      chk("R7 redir_vld", {31'b0, redir_vld}, 32'd1);
      chk("R7 redir_pc", redir_pc, vbr + 32'h100);
      @(negedge clk) idle_inputs();
      @(posedge clk); #1;
      chk("R7 single pulse", {31'b0, redir_vld}, 32'd0);
      chk("R11 no status write", {31'b0, sr_wr_en}, 32'd0);
    end
    last_va  = VEC[NV-1][127:96];
    last_bpc = VEC[NV-1][63:32];
    last_sr  = VEC[NV-1][31:0];

    // R8: fault while blocked
    @(negedge clk);
    flt_req = 1'b1;
    flt_va = 32'h1111_2222;
    flt_in_slot = 1'b0;
    flt_pc = 32'h9000_0000;
    cur_sr = 32'h7000_0000;
    @(posedge clk); #1;
    chk("R8 nest_err", {31'b0, nest_err}, 32'd1);
    chk("R8 no redirect", {31'b0, redir_vld}, 32'd0);
    chk("R8 no status write", {31'b0, sr_wr_en}, 32'd0);
    chk("R8 fault_addr kept", fault_addr, last_va);
    chk("R8 saved_pc kept", saved_pc, last_bpc);
    @(negedge clk) idle_inputs();
    @(posedge clk); #1;
    chk("R8 err single pulse", {31'b0, nest_err}, 32'd0);

    // R9: return
    @(negedge clk) rte_req = 1'b1;
    @(posedge clk); #1;
    chk("R9 redir_vld", {31'b0, redir_vld}, 32'd1);
    chk("R9 redir_pc", redir_pc, last_bpc);
    chk("R9 sr_wr_en", {31'b0, sr_wr_en}, 32'd1);
    chk("R9 sr restore", sr_wr_data, last_sr);
    chk("R9 fault_addr kept", fault_addr, last_va);
    @(negedge clk) idle_inputs();
    @(posedge clk); #1;
    chk("R9 single pulse", {31'b0, redir_vld}, 32'd0);

    // R10: fault and return together
    @(negedge clk);
    flt_req = 1'b1;
    rte_req = 1'b1;
    flt_va = 32'h2468_ACE0;
    flt_op = 3'd0;
    flt_pc = 32'h8C00_9000;
    flt_in_slot = 1'b0;
    cur_sr = 32'h0000_0010;
    cur_vbr = 32'h8800_0000;
    @(posedge clk); #1;
    chk("R10 redir to vector", redir_pc, 32'h8800_0100);
    chk("R10 entry status", sr_wr_data, 32'h7000_0010);
    chk("R10 saved_pc", saved_pc, 32'h8C00_9000);
    @(negedge clk) idle_inputs();
    @(posedge clk); #1;
    chk("R11 quiet", {29'b0, redir_vld, sr_wr_en, nest_err}, 32'd0);

    // R1: reset mid-run
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset saved_sr", saved_sr, 32'd0);
    chk("R1 reset page_num", {12'b0, page_num}, 32'd0);
    chk("R1 reset saved_sp", saved_sp, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule